// File: doc/BRIEF.md
# Receive Frame Buffer with Paged Storage and Completion Queue

This block takes a word-wide receive stream and stores each accepted frame in a pool of fixed-size memory pages. When a frame starts, the lowest-numbered free page is claimed. Its index becomes the frame's handle, and it also serves as the first page of the buffer. Data words go to consecutive logical word offsets, beginning at offset 2. Each logical offset is turned into a physical address of the form page-index/offset-in-page. Whenever the stream crosses a page boundary, another page is claimed.

When the last word has been written, the block spends two more cycles on a header at the start of the first page: a status word at offset 0 and the payload byte count at offset 1. It then pushes the frame handle into a completion queue. The interrupt stays high while that queue holds anything. Software reads the handle at the head of the queue. Once it has finished with the frame, it issues a release command, which pops the handle and returns every page of the frame to the pool.

A frame is thrown away, and all of its pages freed, in three cases: it runs out of pages, it exceeds the per-frame page limit, or it ends with a bad CRC while bad frames are not being kept.

Top module: `rxbuf_top`

## Requirements
- R1: A frame is accepted only when its first beat (`rxSof` with `rxValid`) arrives while `rxEnable` and `rxAddrMatch` are both 1. Beats outside an accepted frame write nothing and queue nothing.
- R2: The first page of a frame is the lowest-indexed free page, and that index is the frame's handle. Each further page is also the lowest-indexed free page, taken on the beat that needs it.
- R3: Payload word k of a frame goes to logical offset L = k+2. The physical address is {page held in slot L / PAGE_WORDS, L mod PAGE_WORDS}. With contiguous pages starting at page 0, this address equals L.
- R4: A frame is dropped with no queue entry in any of these cases. Queue full or no free page at its first beat: the frame is never started. No free page when a new page is needed, or a need for more than MAX_PAGES pages: the frame is stopped and every page it held is freed on the next cycle.
- R5: The status word is written to offset 0 of the first page one cycle after the last beat. Bit 0 is the CRC-bad flag and bit 1 is the odd-final-word flag; the other bits are 0. The byte count is written to offset 1 one cycle later and equals 2*words - odd.
- R6: A frame with a good CRC is pushed into the queue in the cycle that writes its byte count. `rxIrq` and `topValid` are 1 exactly while the queue is non-empty.
- R7: If `keepBadCrc` is 1, a frame whose last beat carries `rxCrcBad` is queued like a good frame. If it is 0, the frame is discarded and its pages are freed.
- R8: `relCmd` pops the queue head, handles leaving in arrival order, and frees all pages of that frame. When the queue is empty, `relCmd` has no effect.
- R9: A release and a page claim in the same cycle both take effect. Pages freed in that cycle are available to the next claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Reception enable |
| keepBadCrc | input | 1 | Queue frames with a bad CRC |
| rxValid | input | 1 | Stream beat valid |
| rxSof | input | 1 | First beat of a frame |
| rxEof | input | 1 | Last beat of a frame |
| rxData | input | DATA_W | Stream data word |
| rxOddLast | input | 1 | Last word holds one byte (sampled on last beat) |
| rxAddrMatch | input | 1 | Destination accepted (sampled on first beat) |
| rxCrcBad | input | 1 | CRC failed (sampled on last beat) |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | PG_W+OFF_W | Physical word address {page, offset} |
| memData | output | DATA_W | Buffer memory write data |
| relCmd | input | 1 | Remove and release queue head |
| topValid | output | 1 | Queue non-empty |
| topPkt | output | PG_W | Handle at queue head |
| rxIrq | output | 1 | Receive interrupt |

## Verification
Two operations can land in the same cycle. In the first, a release returns pages while an in-flight frame claims its next page. The bench provokes this by pulsing `relCmd` on the very beat where a second frame crosses into a new page. It then checks that the in-flight frame is still queued with a correct header, and that a third frame receives the page just freed as its handle. In the second, the push and the pop on the completion queue can coincide; this is judged by the handle order that software sees afterwards.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_HDR0,
    ST_HDR1
  } rxbuf_state_t;

  typedef struct packed {
    logic allocFirst;
    logic allocNext;
    logic writeData;
    logic endBeat;
    logic writeStat;
    logic writeCnt;
    logic commit;
    logic dropCur;
  } rxbuf_strobe_t;

endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEnable,
  input  logic          keepBadCrc,
  input  logic          rxValid,
  input  logic          rxSof,
  input  logic          rxEof,
  input  logic          rxAddrMatch,
  input  logic          anyFree,
  input  logic          qFull,
  input  logic          needPage,
  input  logic          atLimit,
  input  logic          badEnd,
  output rxbuf_strobe_t st
);

  rxbuf_state_t state, nxt;

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (rxValid && rxSof && rxEnable && rxAddrMatch && anyFree && !qFull) begin
          st.allocFirst = 1'b1;
          st.writeData  = 1'b1;
          if (rxEof) begin
            st.endBeat = 1'b1;
            nxt        = ST_HDR0;
          end else begin
            nxt = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (rxValid) begin
          if (needPage && (atLimit || !anyFree)) begin
            st.dropCur = 1'b1;
            nxt        = ST_IDLE;
          end else begin
            st.writeData = 1'b1;
            st.allocNext = needPage;
            if (rxEof) begin
              st.endBeat = 1'b1;
              nxt        = ST_HDR0;
            end
          end
        end
      end
      ST_HDR0: begin
        st.writeStat = 1'b1;
        nxt          = ST_HDR1;
      end
      ST_HDR1: begin
        st.writeCnt = 1'b1;
        if (!badEnd || keepBadCrc) st.commit  = 1'b1;
        else                       st.dropCur = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  AST_HDR_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR0) |=> (state == ST_HDR1)); // R5

endmodule

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 128,
  parameter int NUM_PAGES  = 32,
  parameter int MAX_PAGES  = 4,
  parameter int QDEPTH     = 4,
  localparam int PG_W      = $clog2(NUM_PAGES),
  localparam int OFF_W     = $clog2(PAGE_WORDS),
  localparam int ADDR_W    = PG_W + OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  rxbuf_strobe_t     st,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxOddLast,
  input  logic              rxCrcBad,
  input  logic              relCmd,
  output logic              anyFree,
  output logic              qFull,
  output logic              needPage,
  output logic              atLimit,
  output logic              badEnd,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              topValid,
  output logic [PG_W-1:0]   topPkt,
  output logic              rxIrq
);

  localparam int SLOT_W = $clog2(MAX_PAGES + 1);
  localparam int SL_W   = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
  localparam int IDX_W  = $clog2(MAX_PAGES * PAGE_WORDS) + 1;
  localparam int Q_W    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [NUM_PAGES-1:0] freeMap, allocMask, relMask, dropMask;
  logic [PG_W-1:0]      pageTab [NUM_PAGES][MAX_PAGES];
  logic [SLOT_W-1:0]    pageCnt [NUM_PAGES];
  logic [PG_W-1:0]      curPkt, curPage, allocIdx, wrPage;
  logic [SLOT_W-1:0]    curCnt;
  logic [IDX_W-1:0]     wordIdx, dataWords;
  logic [OFF_W-1:0]     wrOff;
  logic                 oddR, badR;
  logic [PG_W-1:0]      qMem [QDEPTH];
  logic [Q_W-1:0]       qRd, qWr;
  logic [Q_W:0]         qCount;
  logic                 doPop, doPush, doAlloc;

  // lowest-index free page search
  always_comb begin
    allocIdx = '0;
    anyFree  = 1'b0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (freeMap[i]) begin
        allocIdx = PG_W'(i);
        anyFree  = 1'b1;
      end
    end
  end

  assign doAlloc  = st.allocFirst | st.allocNext;
  assign needPage = (wordIdx[OFF_W-1:0] == '0);
  assign atLimit  = (curCnt == SLOT_W'(MAX_PAGES));
  assign badEnd   = badR;
  assign topValid = (qCount != '0);
  assign rxIrq    = topValid;
  assign qFull    = (qCount == (Q_W+1)'(QDEPTH));
  assign topPkt   = qMem[qRd];
  assign doPop    = relCmd && topValid;
  assign doPush   = st.commit;

  always_comb begin
    allocMask = '0;
    relMask   = '0;
    dropMask  = '0;
    if (doAlloc) allocMask[allocIdx] = 1'b1;
    for (int k = 0; k < MAX_PAGES; k++) begin
      if (doPop && (SLOT_W'(k) < pageCnt[topPkt])) relMask[pageTab[topPkt][k]] = 1'b1;
      if (st.dropCur && (SLOT_W'(k) < curCnt))     dropMask[pageTab[curPkt][k]] = 1'b1;
    end
  end

  // write port: payload, then status, then byte count
  assign dataWords = wordIdx - IDX_W'(2);
  always_comb begin
    memWe   = st.writeData | st.writeStat | st.writeCnt;
    wrPage  = curPkt;
    wrOff   = '0;
    memData = '0;
    if (st.writeData) begin
      wrPage  = doAlloc ? allocIdx : curPage;
      wrOff   = st.allocFirst ? OFF_W'(2) : wordIdx[OFF_W-1:0];
      memData = rxData;
    end else if (st.writeStat) begin
      memData = DATA_W'({oddR, badR});
    end else if (st.writeCnt) begin
      wrOff   = OFF_W'(1);
      memData = DATA_W'({dataWords, 1'b0}) - DATA_W'(oddR);
    end
  end
  assign memAddr = {wrPage, wrOff};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMap <= '1;
      curPkt  <= '0;
      curPage <= '0;
      curCnt  <= '0;
      wordIdx <= IDX_W'(2);
      oddR    <= 1'b0;
      badR    <= 1'b0;
      qRd     <= '0;
      qWr     <= '0;
      qCount  <= '0;
    end else begin
      freeMap <= (freeMap | relMask | dropMask) & ~allocMask;
      if (st.allocFirst) begin
        curPkt  <= allocIdx;
        curPage <= allocIdx;
        curCnt  <= SLOT_W'(1);
        wordIdx <= IDX_W'(3);
      end else if (st.writeData) begin
        wordIdx <= wordIdx + IDX_W'(1);
        if (st.allocNext) begin
          curPage <= allocIdx;
          curCnt  <= curCnt + SLOT_W'(1);
        end
      end
      if (st.endBeat) begin
        oddR <= rxOddLast;
        badR <= rxCrcBad;
      end
      if (doPush) qWr <= (qWr == Q_W'(QDEPTH - 1)) ? '0 : qWr + Q_W'(1);
      if (doPop)  qRd <= (qRd == Q_W'(QDEPTH - 1)) ? '0 : qRd + Q_W'(1);
      qCount <= qCount + (Q_W+1)'(doPush) - (Q_W+1)'(doPop);
    end
  end

  // page lists and queue storage need no reset
  always_ff @(posedge clk) begin
    if (st.allocFirst) pageTab[allocIdx][0] <= allocIdx;
    if (st.allocNext)  pageTab[curPkt][curCnt[SL_W-1:0]] <= allocIdx;
    if (doPush) begin
      pageCnt[curPkt] <= curCnt;
      qMem[qWr]       <= curPkt;
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rstN)
    doAlloc |-> freeMap[allocIdx]); // R2
  AST_DROP_FREED: assert property (@(posedge clk) disable iff (!rstN)
    st.dropCur |=> ((freeMap & $past(dropMask)) == $past(dropMask))); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> $past(st.commit)); // R6
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= (Q_W+1)'(QDEPTH)); // R8
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (doPop && !doPush) |=> (qCount == $past(qCount) - (Q_W+1)'(1))); // R8

endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top
  import rxbuf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 128,
  parameter int NUM_PAGES  = 32,
  parameter int MAX_PAGES  = 4,
  parameter int QDEPTH     = 4,
  localparam int PG_W      = $clog2(NUM_PAGES),
  localparam int OFF_W     = $clog2(PAGE_WORDS)
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxEnable,
  input  logic                  keepBadCrc,
  input  logic                  rxValid,
  input  logic                  rxSof,
  input  logic                  rxEof,
  input  logic [DATA_W-1:0]     rxData,
  input  logic                  rxOddLast,
  input  logic                  rxAddrMatch,
  input  logic                  rxCrcBad,
  output logic                  memWe,
  output logic [PG_W+OFF_W-1:0] memAddr,
  output logic [DATA_W-1:0]     memData,
  input  logic                  relCmd,
  output logic                  topValid,
  output logic [PG_W-1:0]       topPkt,
  output logic                  rxIrq
);

  rxbuf_strobe_t st;
  logic anyFree, qFull, needPage, atLimit, badEnd;

  rxbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .keepBadCrc(keepBadCrc),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxAddrMatch(rxAddrMatch),
    .anyFree(anyFree), .qFull(qFull), .needPage(needPage), .atLimit(atLimit),
    .badEnd(badEnd), .st(st)
  );

  rxbuf_datapath #(
    .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES),
    .MAX_PAGES(MAX_PAGES), .QDEPTH(QDEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .rxData(rxData), .rxOddLast(rxOddLast),
    .rxCrcBad(rxCrcBad), .relCmd(relCmd), .anyFree(anyFree), .qFull(qFull),
    .needPage(needPage), .atLimit(atLimit), .badEnd(badEnd), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .topValid(topValid), .topPkt(topPkt),
    .rxIrq(rxIrq)
  );

endmodule

// File: tb/rxbuf_top_bench.sv
module rxbuf_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 4;
  localparam int NP   = 8;
  localparam int MAXP = 3;
  localparam int QD   = 4;
  localparam int MAXW = MAXP * PW - 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxEnable = 1'b0, keepBadCrc = 1'b0, rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic [15:0] rxData = '0;
  logic rxOddLast = 1'b0, rxAddrMatch = 1'b0, rxCrcBad = 1'b0, relCmd = 1'b0;
  logic memWe, topValid, rxIrq;
  logic [4:0] memAddr;
  logic [15:0] memData;
  logic [2:0] topPkt;
  logic [15:0] mem [32];
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_top #(.DATA_W(16), .PAGE_WORDS(PW), .NUM_PAGES(NP), .MAX_PAGES(MAXP), .QDEPTH(QD)) u_rxbuf_top (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .keepBadCrc(keepBadCrc), .rxValid(rxValid),
    .rxSof(rxSof), .rxEof(rxEof), .rxData(rxData), .rxOddLast(rxOddLast),
    .rxAddrMatch(rxAddrMatch), .rxCrcBad(rxCrcBad), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .relCmd(relCmd), .topValid(topValid), .topPkt(topPkt), .rxIrq(rxIrq)
  );

  always @(posedge clk) if (memWe) mem[memAddr] <= memData;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(int n, bit odd, bit bad, bit en, bit match, logic [7:0] tag);
    rxEnable = en;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = (k == 0); rxEof = (k == n - 1);
      rxData = {tag, 8'(k)}; rxOddLast = odd && (k == n - 1);
      rxCrcBad = bad && (k == n - 1); rxAddrMatch = match;
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; rxOddLast = 1'b0; rxCrcBad = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release1();
    @(negedge clk); relCmd = 1'b1;
    @(negedge clk); relCmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chkHeader(int pkt, int n, bit odd, bit bad, string req);
    chk(mem[{3'(pkt), 2'd0}] == 16'({odd, bad}), req, int'(mem[{3'(pkt), 2'd0}]), int'({odd, bad}));
    chk(mem[{3'(pkt), 2'd1}] == 16'(2*n - int'(odd)), req, int'(mem[{3'(pkt), 2'd1}]), 2*n - int'(odd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rxIrq == 1'b0 && topValid == 1'b0 && memWe == 1'b0, "reset", int'(rxIrq), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: release on empty queue has no effect
    release1();
    chk(rxIrq == 1'b0, "R8 empty release", int'(rxIrq), 0);

    // R1: disabled or unmatched frames ignored
    sendFrame(3, 0, 0, 0, 1, 8'h11);
    chk(rxIrq == 1'b0 && topValid == 1'b0, "R1 disabled", int'(rxIrq), 0);
    sendFrame(3, 0, 0, 1, 0, 8'h12);
    chk(rxIrq == 1'b0 && topValid == 1'b0, "R1 no match", int'(rxIrq), 0);

    // Sweep length x odd x bad x keep (R2 R3 R4 R5 R6 R7)
    for (int n = 1; n <= MAXW + 1; n++) begin
      for (int v = 0; v < 8; v++) begin
        bit odd, bad, keep, queued;
        logic [7:0] tag;
        odd = v[0]; bad = v[1]; keep = v[2];
        tag = 8'(n * 8 + v);
        keepBadCrc = keep;
        queued = (n <= MAXW) && (!bad || keep);
        sendFrame(n, odd, bad, 1, 1, tag);
        chk(rxIrq == queued, (n > MAXW) ? "R4 page limit" : (bad ? "R7 bad crc" : "R6 good crc"),
            int'(rxIrq), int'(queued));
        if (queued) begin
          chk(topPkt == 3'd0, "R2 first page", int'(topPkt), 0);
          chkHeader(0, n, odd, bad, "R5 header");
          for (int k = 0; k < n; k++)
            chk(mem[k + 2] == {tag, 8'(k)}, "R3 payload", int'(mem[k + 2]), int'({tag, 8'(k)}));
          release1();
          chk(rxIrq == 1'b0, "R8 pop", int'(rxIrq), 0);
        end
      end
    end
    keepBadCrc = 1'b0;

    // R4: queue full at start -> frame ignored; R8 FIFO order
    for (int i = 0; i < QD + 1; i++) sendFrame(1, 0, 0, 1, 1, 8'(8'hC0 + i));
    for (int i = 0; i < QD; i++) begin
      chk(topValid && topPkt == 3'(i), "R8 order", int'(topPkt), i);
      release1();
    end
    chk(rxIrq == 1'b0, "R4 queue full drop", int'(rxIrq), 0);

    // R4: pool exhaustion mid-frame
    sendFrame(MAXW, 0, 0, 1, 1, 8'hD0);
    sendFrame(MAXW, 0, 0, 1, 1, 8'hD1);
    sendFrame(MAXW, 1, 0, 1, 1, 8'hD2);
    chk(topPkt == 3'd0, "R2 first frame pkt", int'(topPkt), 0);
    release1();
    chk(topPkt == 3'd3, "R4 exhaust drop", int'(topPkt), 3);
    release1();
    chk(rxIrq == 1'b0, "R4 exhaust no queue", int'(rxIrq), 0);
    sendFrame(1, 0, 0, 1, 1, 8'hD3);
    chk(topPkt == 3'd0, "R4 pages freed", int'(topPkt), 0);
    release1();

    // R9: release coincides with a page claim
    sendFrame(1, 0, 0, 1, 1, 8'hE0);           // handle 0
    fork
      sendFrame(6, 1, 0, 1, 1, 8'hE1);         // handle 1, pages 1 and 2
      begin repeat (3) @(negedge clk); relCmd = 1'b1; @(negedge clk); relCmd = 1'b0; end
    join
    chk(topValid && topPkt == 3'd1, "R9 frame queued", int'(topPkt), 1);
    chkHeader(1, 6, 1, 0, "R9 header");
    sendFrame(1, 0, 0, 1, 1, 8'hE2);
    release1();
    chk(topPkt == 3'd0, "R9 freed page reused", int'(topPkt), 0);
    release1();
    chk(rxIrq == 1'b0, "R9 drained", int'(rxIrq), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule